// File: doc/BRIEF.md
# Serial EEPROM Write-Side Slave Engine

This block is the write half of a 256-byte two-wire serial EEPROM slave. It samples the clock and data lines into the system clock domain and finds Start and Stop conditions. It then checks the control byte, takes the word address, and collects data bytes into a one-page buffer. When the master sends Stop, the buffered bytes go into a behavioural memory array during a fixed-length internal write cycle. The slave drives the data line only to acknowledge, and it does so through an open-drain pull-down output.

The transfer is handled by one state machine. Its states are ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK and ST_SKIP. The transitions work as follows:
- A Start from any state enters ST_CTRL, and a Stop from any state returns to ST_IDLE.
- When the eighth bit of a byte ends with an SCL fall, each receive state moves to its acknowledge state. The exception is a refused control byte, which moves from ST_CTRL to ST_SKIP.
- The next SCL fall moves ST_CTRL_ACK to ST_ADDR, ST_ADDR_ACK to ST_DATA, and ST_DATA_ACK back to ST_DATA.
- ST_IDLE and ST_SKIP wait for the next bus condition.

A combinational read port exposes the array contents for the read side of the device.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After reset the slave does not pull SDA low, and every array byte reads 00h.
- R2: The slave acknowledges a control byte only when all of these hold: bits 7:4 are 1010, bit 0 (R/W) is 0, the write cycle is idle, and, with CHECK_CS set, bits 3:1 equal the chip_sel straps. Otherwise it leaves SDA released on the ninth clock and ignores the bus until the next Start. The acknowledge pull-down changes only while SCL is low.
- R3: The slave acknowledges the byte that follows an accepted control byte, and that byte loads the 8-bit address pointer.
- R4: The slave acknowledges every later byte and places it at the pointer. Only pointer bits 2:0 then increment, and bits 7:3 stay fixed.
- R5: If more than 8 data bytes arrive before Stop, the pointer wraps within the page, and the later bytes replace the earlier ones.
- R6: The array changes only during a write cycle that a Stop starts after at least one complete data byte. Only page locations that received data are written. A Stop right after the address byte writes nothing and starts no write cycle.
- R7: A Start that arrives before Stop discards all buffered bytes, and no write cycle follows.
- R8: The internal write cycle lasts exactly WR_CYCLES system clocks, and no control byte is acknowledged while it runs.
- R9: Bytes at addresses 80h to FFh never change. They are still acknowledged on the bus.
- R10: rd_data always shows the array byte at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| chip_sel | input | 3 | Strap value compared with control bits 3:1 |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The checker watches four things on every cycle:
- the acknowledge pull-down never rises while SCL is high;
- a control acknowledge never happens during a write cycle, and each write cycle lasts exactly WR_CYCLES clocks;
- the page bits of the pointer hold across data bytes, and the array is written only inside a write cycle;
- the protected half always reads zero.

Where bytes land is a different matter, and only the bench scenarios can show it. That covers page wrap and overrun, the untouched neighbours of a partial page, buffers thrown away by a repeated Start, polling during a write cycle, and a sweep of one write into each of the 32 pages. In each case the bench compares the array against its own arithmetic model.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } wr_state_e;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_N-1:0] scl_ff;
    logic [SYNC_N-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_N-2:0], scl_raw};
            sda_ff <= {sda_ff[SYNC_N-2:0], sda_raw};
            scl_q  <= scl_ff[SYNC_N-1];
            sda_q  <= sda_ff[SYNC_N-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_N-1];
    assign sda_s     = sda_ff[SYNC_N-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SCL high on both samples; only SDA moved
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eeprom_wr_fsm.sv
module eeprom_wr_fsm
    import eeprom_wr_pkg::*;
#(
    parameter bit CHECK_CS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [2:0]        cs_pins,
    input  logic              busy,
    output logic              sda_oe,
    output logic              addr_ld,
    output logic              data_wr,
    output logic              buf_clr,
    output logic              commit,
    output logic [BYTE_W-1:0] rx_byte,
    output wr_state_e         st
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    wr_state_e        st_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic             cs_ok;
    logic             ctrl_ok;
    logic             byte_end;
    logic             rx_st;
    logic             ack_st;

    generate
        if (CHECK_CS) begin : g_cs_cmp
            assign cs_ok = (shreg[3:1] == cs_pins);
        end else begin : g_cs_any
            assign cs_ok = 1'b1;
        end
    endgenerate

    assign ctrl_ok  = (shreg[7:4] == DEV_CODE) && !shreg[0] && cs_ok && !busy;
    assign byte_end = scl_fall && (bit_cnt == FULL);
    assign rx_st    = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_DATA);
    assign ack_st   = (st == ST_CTRL_ACK) || (st == ST_ADDR_ACK) || (st == ST_DATA_ACK);
    assign rx_byte  = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = ST_CTRL;
        end else if (stop_det) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_SKIP:     st_nx = ST_SKIP;
                ST_CTRL:     if (byte_end) st_nx = ctrl_ok ? ST_CTRL_ACK : ST_SKIP;
                ST_ADDR:     if (byte_end) st_nx = ST_ADDR_ACK;
                ST_DATA:     if (byte_end) st_nx = ST_DATA_ACK;
                ST_CTRL_ACK: if (scl_fall) st_nx = ST_ADDR;
                ST_ADDR_ACK: if (scl_fall) st_nx = ST_DATA;
                ST_DATA_ACK: if (scl_fall) st_nx = ST_DATA;
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // bit shifter and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else if (rx_st && scl_rise && (bit_cnt != FULL)) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (ack_st && scl_fall) begin
            bit_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        sda_oe  = ack_st;
        buf_clr = start_det;
        addr_ld = (st == ST_ADDR) && byte_end && !start_det && !stop_det;
        data_wr = (st == ST_DATA) && byte_end && !start_det && !stop_det;
        commit  = stop_det && ((st == ST_DATA) || (st == ST_DATA_ACK));
    end

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 400
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BYTE_W-1:0]        rx_byte,
    input  logic                     addr_ld,
    input  logic                     data_wr,
    input  logic                     buf_clr,
    input  logic                     commit,
    output logic                     busy,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_waddr,
    output logic [BYTE_W-1:0]        mem_wdata,
    output logic [ADDR_W-PAGE_W-1:0] cur_page
);

    localparam int PAGE  = 1 << PAGE_W;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int CYC_W = $clog2(WR_CYCLES + 1);

    logic [PG_W-1:0]   pg_q;
    logic [PAGE_W-1:0] off_q;
    logic [BYTE_W-1:0] pbuf [PAGE];
    logic [PAGE-1:0]   vmask;
    logic [PAGE-1:0]   cmask;
    logic [PG_W-1:0]   cpage;
    logic [CYC_W-1:0]  cyc;
    logic [PAGE_W-1:0] idx;

    assign cur_page = pg_q;

    // address pointer: page part frozen while data streams in
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q  <= '0;
            off_q <= '0;
        end else if (addr_ld) begin
            pg_q  <= rx_byte[ADDR_W-1:PAGE_W];
            off_q <= rx_byte[PAGE_W-1:0];
        end else if (data_wr) begin
            off_q <= off_q + 1'b1;
        end
    end

    // page storage with a received-location mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vmask <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
        end else if (buf_clr || commit) begin
            vmask <= '0;
        end else if (data_wr) begin
            pbuf[off_q]  <= rx_byte;
            vmask[off_q] <= 1'b1;
        end
    end

    // write cycle sequencer: one page slot per clock, then idle out the rest
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cyc   <= '0;
            cmask <= '0;
            cpage <= '0;
        end else if (!busy) begin
            if (commit && (vmask != '0)) begin
                busy  <= 1'b1;
                cyc   <= '0;
                cmask <= vmask;
                cpage <= pg_q;
            end
        end else begin
            cyc <= cyc + 1'b1;
            if (cyc == CYC_W'(WR_CYCLES - 1)) busy <= 1'b0;
        end
    end

    assign idx       = cyc[PAGE_W-1:0];
    assign mem_we    = busy && (cyc < CYC_W'(PAGE)) && cmask[idx];
    assign mem_waddr = {cpage, idx};
    assign mem_wdata = pbuf[idx];

endmodule

// File: rtl/eeprom_mem_array.sv
module eeprom_mem_array
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              wr_ok;

    // top half of the address space is locked
    assign wr_ok = we && !waddr[ADDR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 400,
    parameter bit CHECK_CS  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic [2:0]        chip_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              addr_ld, data_wr, buf_clr, commit, busy, mem_we;
    logic [BYTE_W-1:0] rx_byte, mem_wdata;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-PAGE_W-1:0] cur_page;
    wr_state_e         wr_st;

    eeprom_bus_sync #(.SYNC_N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_wr_fsm #(.CHECK_CS(CHECK_CS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .cs_pins(chip_sel), .busy(busy), .sda_oe(sda_pull), .addr_ld(addr_ld),
        .data_wr(data_wr), .buf_clr(buf_clr), .commit(commit),
        .rx_byte(rx_byte), .st(wr_st)
    );

    eeprom_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_buf (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .addr_ld(addr_ld),
        .data_wr(data_wr), .buf_clr(buf_clr), .commit(commit), .busy(busy),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cur_page(cur_page)
    );

    eeprom_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

endmodule

// File: rtl/eeprom_wr_chk.sv
module eeprom_wr_chk
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 400
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_s,
    input logic                     sda_oe,
    input logic                     busy,
    input wr_state_e                st,
    input logic                     data_wr,
    input logic [ADDR_W-PAGE_W-1:0] page,
    input logic                     mem_we,
    input logic                     prot_sel,
    input logic [7:0]               rd_data
);

    localparam int CNT_W = $clog2(WR_CYCLES + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (busy)  busy_cnt <= busy_cnt + 1'b1;
        else            busy_cnt <= '0;
    end

    // R2
    ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R8
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CTRL_ACK) |-> !busy);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CNT_W'(WR_CYCLES)));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> $stable(page));

    // R6
    commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R9
    prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_sel |-> (rd_data == 8'h00));

endmodule

bind eeprom_wr_slave eeprom_wr_chk #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_pull), .busy(busy),
    .st(wr_st), .data_wr(data_wr), .page(cur_page), .mem_we(mem_we),
    .prot_sel(rd_addr[ADDR_W-1]), .rd_data(rd_data)
);

// File: tb/test_eeprom_wr_slave.sv
module test_eeprom_wr_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WR_C       = 400;
    localparam logic [2:0] CS = 3'b101;
    localparam logic [7:0] CTRL_W = {4'b1010, CS, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       sda_pull;
    logic       sda_bus;
    logic [7:0] exp_mem [256];
    int         total = 0;
    int         bad = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wr_slave #(.ADDR_W(8), .PAGE_W(3), .WR_CYCLES(WR_C), .CHECK_CS(1'b1)) i_eeprom_wr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull(sda_pull), .chip_sel(CS), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] dval(input int seed, input int k);
        return 8'((seed + k * 29 + 3) & 255);
    endfunction

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // full write transfer; updates the model from the requirements
    task automatic write_txn(input logic [7:0] addr, input int n, input int seed,
                             input bit wait_done, input string req);
        bit a0, a1, ak, all;
        logic [7:0] a;
        bus_start;
        send_byte(CTRL_W, a0);
        send_byte(addr, a1);
        all = a0 & a1;
        for (int k = 0; k < n; k++) begin
            send_byte(dval(seed, k), ak);
            all &= ak;
        end
        bus_stop;
        chk(all, req, int'(all), 1);
        if (a0) begin
            for (int k = 0; k < n; k++) begin
                a = {addr[7:3], 3'(int'(addr[2:0]) + k)};
                if (!a[7]) exp_mem[a] = dval(seed, k);
            end
        end
        if (wait_done) tick(WR_C + 20);
    endtask

    task automatic poll(input bit expect_ack, input string req);
        bit a;
        bus_start;
        send_byte(CTRL_W, a);
        bus_stop;
        chk(a == expect_ack, req, int'(a), int'(expect_ack));
    endtask

    // R10 read port compared with the model at every address
    task automatic check_mem_all(input string req);
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #1;
            chk(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk(sda_pull == 1'b0, "R1 idle release", int'(sda_pull), 0);
        check_mem_all("R1 R10 reset contents");

        // R2 R3 R4 single byte, then R8 polling during write cycle
        write_txn(8'h10, 1, 7, 1'b0, "R2 R3 R4 byte write acks");
        poll(1'b0, "R8 no ack while writing");
        tick(WR_C + 20);
        poll(1'b1, "R8 ack after write cycle");
        check_mem_all("R4 R6 byte write");

        // R4 page write starting mid-page wraps within the page
        write_txn(8'h23, 8, 40, 1'b1, "R4 page write acks");
        check_mem_all("R4 page wrap");

        // R5 overrun: 11 bytes into an 8-byte page
        write_txn(8'h40, 11, 90, 1'b1, "R5 overrun acks");
        check_mem_all("R5 overrun overwrite");

        // R6 partial page leaves neighbours alone
        write_txn(8'h50, 8, 120, 1'b1, "R6 fill page");
        write_txn(8'h55, 2, 200, 1'b1, "R6 partial acks");
        check_mem_all("R6 partial page");

        // R6 stop after address only: no write cycle
        bus_start;
        send_byte(CTRL_W, a);
        send_byte(8'h30, a);
        bus_stop;
        poll(1'b1, "R6 no cycle after address-only");
        check_mem_all("R6 address-only");

        // R7 repeated start discards the buffer
        bus_start;
        send_byte(CTRL_W, a);
        send_byte(8'h60, a);
        send_byte(8'hC3, a);
        send_byte(8'h3C, a);
        bus_start;
        bus_stop;
        poll(1'b1, "R7 no cycle after discard");
        check_mem_all("R7 discarded data");

        // R9 protected half: acknowledged yet unchanged
        write_txn(8'h90, 5, 33, 1'b1, "R9 protected acks");
        write_txn(8'hFF, 1, 77, 1'b1, "R9 protected byte ack");
        check_mem_all("R9 protected half");

        // R2 refused control bytes
        bus_start;
        send_byte({4'b1011, CS, 1'b0}, a);
        chk(!a, "R2 wrong device code", int'(a), 0);
        send_byte(8'h12, a);
        chk(!a, "R2 ignored after refusal", int'(a), 0);
        send_byte(8'h77, a);
        bus_stop;
        bus_start;
        send_byte({4'b1010, 3'b000, 1'b0}, a);
        chk(!a, "R2 chip select mismatch", int'(a), 0);
        bus_stop;
        bus_start;
        send_byte({4'b1010, CS, 1'b1}, a);
        chk(!a, "R2 read direction", int'(a), 0);
        bus_stop;
        tick(WR_C + 20);
        check_mem_all("R2 refused transfers write nothing");

        // R4 R9 sweep: one byte into every page
        for (int p = 0; p < 32; p++) begin
            write_txn(8'(p * 8 + (p % 8)), 1, p * 37 + 11, 1'b1, "R4 sweep acks");
        end
        check_mem_all("R4 R9 sweep");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule